// File: doc/BRIEF.md
# Seconds Counter Register Block

This block keeps a free-running 32-bit count of elapsed seconds and exposes it to software as byte-wide registers on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. The count advances by one on each single-cycle `tick` pulse while counting is enabled. A control register gates counting. A fixed identification register lets software recognise the block.

Software loads a new time through four write-only byte registers. Each write replaces the matching byte of the live count on the next clock edge. The block supports a safe load order: zero the low byte first, then write the upper three bytes, then write the low byte last. With the low byte starting at zero, at least 256 ticks must pass before any carry can reach the upper bytes, so the sequence cannot be corrupted by a stray carry.

Reads return the live count with no snapshot. A read of several bytes can therefore straddle a carry. Software detects this by reading the low byte again and finding it smaller than before.

The register bus carries plain register accesses rather than a data stream, so it has no valid/ready handshake. Every access completes in the cycle it is presented and can never be back-pressured.

Top module: `rtc_seconds_regs`

## Requirements
- R1: After reset the count is 0 and counting is disabled, so every count byte and the control register read 0x00.
- R2: Offsets 0x48+k (k = 0..3) read byte k of the live count combinationally, with byte 0 as the least significant (little-endian). No value is latched between reads.
- R3: Bit 7 of the control register at offset 0x46 enables counting. A write stores only bit 7. A read returns the stored bit in bit 7, with bits 6..0 reading as 0.
- R4: While counting is disabled, or when `tick` is low, the count holds its value.
- R5: While enabled, each clock cycle with `tick` high adds exactly 1 to the count, and 0xFFFFFFFF wraps to 0x00000000.
- R6: A write to offset 0x40+k (k = 0..3) replaces byte k of the count on the next edge and leaves the other bytes untouched.
- R7: When a count-byte write and a tick fall in the same cycle, the write takes effect and that cycle's increment is dropped.
- R8: Offset 0x05 always reads 0x01, and writes to it have no effect.
- R9: Every other offset reads 0x00, including the write-only offsets 0x40..0x43. Writes to any offset other than 0x40..0x43 and 0x46 change neither the count nor the enable.
- R10: With counting enabled, the load order (byte 0 cleared, then bytes 1..3, then byte 0) leaves the upper bytes exactly as written, even when ticks fall between the writes.
- R11: When a carry out of byte 0 happens between reading byte 0 and byte 1, a second read of byte 0 returns a smaller value than the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe for the offset on `bus_addr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |

## Verification
On every cycle, the checker enforces four behaviours. The count must hold when it is disabled or idle. It must step by exactly one on an enabled tick. A byte write must land in exactly that byte on the next edge. The read mux must show the live count, the fixed identifier and the zero bits of the control register. It also confirms that writes to unmapped offsets disturb nothing. Other behaviours need multi-step histories that only the bench scenarios build: the wrap from all-ones, the write-beats-tick priority seen across a whole load, the carry-free ordered load, and detection of a straddled read by re-reading byte 0.

// File: rtl/rtc_secs_pkg.sv
`timescale 1ns/1ps
package rtc_secs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WBYTE,
    SEL_CTRL,
    SEL_RBYTE,
    SEL_ID
  } sel_kind_e;
endpackage

// File: rtl/rtc_secs_decode.sv
`timescale 1ns/1ps
module rtc_secs_decode
  import rtc_secs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BYTES    = 4,
  parameter int unsigned WBASE    = 'h40,
  parameter int unsigned CTRL_OFS = 'h46,
  parameter int unsigned RBASE    = 'h48,
  parameter int unsigned ID_OFS   = 'h05,
  localparam int unsigned IDX_W   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    if (addr == ADDR_W'(CTRL_OFS)) kind = SEL_CTRL;
    if (addr == ADDR_W'(ID_OFS))   kind = SEL_ID;
    for (int k = 0; k < BYTES; k++) begin
      if (addr == ADDR_W'(WBASE + k)) begin
        kind = SEL_WBYTE;
        idx  = IDX_W'(k);
      end
      if (addr == ADDR_W'(RBASE + k)) begin
        kind = SEL_RBYTE;
        idx  = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/rtc_secs_counter.sv
`timescale 1ns/1ps
module rtc_secs_counter
  import rtc_secs_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned CNT_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [BYTES-1:0]  byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] nxt;
  logic             step;

  // a load in this cycle suppresses the increment entirely
  assign step = en && tick && (byte_we == '0);
  assign inc  = cnt + CNT_W'(1);

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign nxt[k*BYTE_W +: BYTE_W] =
      byte_we[k] ? wdata :
      step       ? inc[k*BYTE_W +: BYTE_W] :
                   cnt[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/rtc_secs_rdmux.sv
`timescale 1ns/1ps
module rtc_secs_rdmux
  import rtc_secs_pkg::*;
#(
  parameter int unsigned BYTES  = 4,
  parameter int unsigned EN_BIT = 7,
  parameter logic [7:0]  ID_VAL = 8'h01,
  localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int unsigned CNT_W = BYTES * BYTE_W
) (
  input  sel_kind_e         kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              en,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] byte_arr [BYTES];

  for (genvar k = 0; k < BYTES; k++) begin : g_split
    assign byte_arr[k] = cnt[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rdata = '0;
    unique case (kind)
      SEL_RBYTE: rdata = byte_arr[idx];
      SEL_CTRL:  rdata[EN_BIT] = en;
      SEL_ID:    rdata = ID_VAL;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_seconds_regs.sv
`timescale 1ns/1ps
module rtc_seconds_regs
  import rtc_secs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BYTES    = 4,
  parameter int unsigned WBASE    = 'h40,
  parameter int unsigned CTRL_OFS = 'h46,
  parameter int unsigned RBASE    = 'h48,
  parameter int unsigned ID_OFS   = 'h05,
  parameter int unsigned EN_BIT   = 7,
  parameter logic [7:0]  ID_VAL   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int unsigned CNT_W = BYTES * BYTE_W;

  sel_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [BYTES-1:0] byte_we;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  rtc_secs_decode #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .WBASE(WBASE),
    .CTRL_OFS(CTRL_OFS), .RBASE(RBASE), .ID_OFS(ID_OFS)
  ) dec_i (
    .addr(bus_addr), .kind(kind), .idx(idx)
  );

  for (genvar k = 0; k < BYTES; k++) begin : g_we
    assign byte_we[k] = bus_wr && (kind == SEL_WBYTE) && (idx == IDX_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           en_q <= 1'b0;
    else if (bus_wr && kind == SEL_CTRL)  en_q <= bus_wdata[EN_BIT];
  end

  rtc_secs_counter #(.BYTES(BYTES)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick),
    .byte_we(byte_we), .wdata(bus_wdata), .cnt(cnt_q)
  );

  rtc_secs_rdmux #(.BYTES(BYTES), .EN_BIT(EN_BIT), .ID_VAL(ID_VAL)) rd_i (
    .kind(kind), .idx(idx), .cnt(cnt_q), .en(en_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/rtc_seconds_regs_chk.sv
`timescale 1ns/1ps
module rtc_seconds_regs_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BYTES    = 4,
  parameter int unsigned WBASE    = 'h40,
  parameter int unsigned CTRL_OFS = 'h46,
  parameter int unsigned RBASE    = 'h48,
  parameter int unsigned ID_OFS   = 'h05,
  parameter int unsigned EN_BIT   = 7,
  parameter logic [7:0]  ID_VAL   = 8'h01,
  localparam int unsigned CNT_W   = BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              en
);
  logic hit_cnt, hit_ctrl, wr_cnt, wr_other;
  assign hit_cnt  = (bus_addr >= ADDR_W'(WBASE)) && (bus_addr < ADDR_W'(WBASE + BYTES));
  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign wr_cnt   = bus_wr && hit_cnt;
  assign wr_other = bus_wr && !hit_cnt && !hit_ctrl;

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt) |=> $stable(cnt)) else $error("count moved while disabled"); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt)) else $error("count moved without tick"); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !wr_cnt) |=> (cnt == $past(cnt) + CNT_W'(1))) else $error("bad step"); // R5
  AST_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |-> (bus_rdata == (8'(en) << EN_BIT))) else $error("control readback"); // R3
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(ID_OFS)) |-> (bus_rdata == ID_VAL)) else $error("identifier"); // R8
  AST_NO_SIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_other && !(en && tick)) |=> ($stable(cnt) && $stable(en))) else $error("stray write"); // R9

  for (genvar k = 0; k < BYTES; k++) begin : g_chk
    AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(WBASE + k)) |=> (cnt[k*8 +: 8] == $past(bus_wdata)))
      else $error("byte load"); // R6
    AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(RBASE + k)) |-> (bus_rdata == cnt[k*8 +: 8]))
      else $error("live read"); // R2
  end
endmodule

bind rtc_seconds_regs rtc_seconds_regs_chk #(
  .ADDR_W(ADDR_W), .BYTES(BYTES), .WBASE(WBASE), .CTRL_OFS(CTRL_OFS),
  .RBASE(RBASE), .ID_OFS(ID_OFS), .EN_BIT(EN_BIT), .ID_VAL(ID_VAL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt_q), .en(en_q)
);

// File: tb/rtc_seconds_regs_tb.sv
`timescale 1ns/1ps
module rtc_seconds_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_cnt = 32'h0;
  logic        exp_en = 1'b0;

  always #5 clk = ~clk;

  rtc_seconds_regs dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a >= 8'h48 && a <= 8'h4B) return exp_cnt[(a - 8'h48) * 8 +: 8];
    if (a == 8'h46) return {exp_en, 7'b0};
    if (a == 8'h05) return 8'h01;
    return 8'h00;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h40 && a <= 8'h43) exp_cnt[(a - 8'h40) * 8 +: 8] = d;
    if (a == 8'h46) exp_en = d[7];
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    model_wr(a, d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    if (exp_en) exp_cnt = exp_cnt + 32'(n);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic check_rd(input string req, input logic [7:0] a);
    logic [7:0] v;
    bus_read(a, v);
    check(req, $sformatf("read @%h", a), 32'(v), 32'(model_rd(a)));
  endtask

  task automatic check_count(input string req);
    logic [7:0] v;
    logic [31:0] got;
    for (int k = 0; k < 4; k++) begin
      bus_read(8'(8'h48 + k), v);
      got[k*8 +: 8] = v;
    end
    check(req, "count", got, exp_cnt);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++) check_rd(req, 8'(a));
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] b0a, b0b, b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, full map incl. identifier and unmapped reads (R8, R9)
    sweep("R1");

    // R3 control: only bit 7 stored
    bus_write(8'h46, 8'hFF, 0);
    check_rd("R3", 8'h46);
    bus_write(8'h46, 8'h7F, 0);
    check_rd("R3", 8'h46);

    // R6 byte loads while disabled; R2 live little-endian read
    bus_write(8'h40, 8'h11, 0);
    bus_write(8'h41, 8'h22, 0);
    bus_write(8'h42, 8'h33, 0);
    bus_write(8'h43, 8'h44, 0);
    check_count("R6");
    sweep("R2");

    // R4 ticks ignored while disabled
    ticks(10);
    check_count("R4");

    // R5 counting with carries, then wrap
    bus_write(8'h46, 8'h80, 0);
    ticks(300);
    check_count("R5");
    bus_write(8'h46, 8'h00, 0);
    bus_write(8'h40, 8'hFD, 0);
    bus_write(8'h41, 8'hFF, 0);
    bus_write(8'h42, 8'hFF, 0);
    bus_write(8'h43, 8'hFF, 0);
    bus_write(8'h46, 8'h80, 0);
    ticks(5);
    check("R5", "wrap", exp_cnt, 32'h0000_0002);
    check_count("R5");

    // R7 write and tick together: write wins, no increment
    bus_write(8'h42, 8'h5A, 1);
    check_count("R7");
    bus_write(8'h40, 8'h07, 1);
    check_count("R7");

    // R9 writes to every other offset disturb nothing (R8 for 0x05)
    bus_write(8'h46, 8'h00, 0);
    for (int a = 0; a < 256; a++) begin
      if ((a >= 'h40 && a <= 'h43) || a == 'h46) continue;
      bus_write(8'(a), 8'hA5, 0);
      check_count("R9");
      check_rd("R9", 8'h46);
    end
    check_rd("R8", 8'h05);

    // R10 ordered load with counting running
    bus_write(8'h46, 8'h80, 0);
    bus_write(8'h40, 8'h00, 0);
    ticks(3);
    bus_write(8'h41, 8'h56, 0);
    ticks(3);
    bus_write(8'h42, 8'h34, 0);
    ticks(3);
    bus_write(8'h43, 8'h12, 0);
    ticks(3);
    check_rd("R10", 8'h49);
    check_rd("R10", 8'h4A);
    check_rd("R10", 8'h4B);
    bus_write(8'h40, 8'h78, 0);
    check("R10", "final", exp_cnt, 32'h1234_5678);
    check_count("R10");

    // R11 straddled read detected by re-reading byte 0
    bus_write(8'h46, 8'h00, 0);
    bus_write(8'h43, 8'h00, 0);
    bus_write(8'h42, 8'h00, 0);
    bus_write(8'h41, 8'h00, 0);
    bus_write(8'h40, 8'hFF, 0);
    bus_write(8'h46, 8'h80, 0);
    bus_read(8'h48, b0a);
    ticks(1);
    bus_read(8'h49, b1);
    bus_read(8'h48, b0b);
    check("R11", "first byte0", 32'(b0a), 32'hFF);
    check("R11", "byte1", 32'(b1), 32'h01);
    check("R11", "second byte0 smaller", 32'(b0b < b0a), 32'h1);
    check_count("R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule